// File: doc/BRIEF.md
# Second-Order Digital Delta-Sigma Bitstream Modulator

This block converts a signed multi-bit sample into a single-bit stream whose density of ones follows the input value. Two saturating accumulators sit in a loop around a sign comparator. The registered output bit feeds back as a plus or minus full-scale value. The quantisation error is shaped away from low frequencies with a second-order characteristic, so a simple decimating filter downstream can recover the input with high resolution.

It serves as a stimulus and reference source for bitstream decimation filters. The caller holds a sample on the input for many clocks. One output bit comes out per clock. The bit is updated on the falling clock edge, so a filter clocked on the rising edge always samples a settled value. The input scaling gives a defined linear span. Past a wider threshold the stream is forced to a constant level.

Top module: `dsm2_mod`

## Requirements
- R1: While reset is asserted, the output is 0. After reset is released, the output stays 0 until the first falling clock edge.
- R2: A held input of 0 gives a ones density of 50% (2048 of 4096 bits, ±41).
- R3: For a held input x with |x| ≤ 18432, the number of ones in 4096 consecutive bits is 2048 + x/16, within ±41 (density 0.5 + x/65536, ±1%).
- R4: An input of +18432 gives about 78.1% ones (3200 of 4096). An input of -18432 gives about 21.9% ones (896 of 4096). Both are within ±41.
- R5: An input ≥ +23593 makes every output bit 1. An input ≤ -23593 makes every output bit 0.
- R6: In the band 18432 < |x| < 23593, the stream is not constant. For positive x, the count of ones over 4096 bits is at least 3159 and below 4096. For negative x, it is above 0 and at most 937.
- R7: The output changes only on falling clock edges. Its value just after a rising edge equals its value just after the preceding falling edge.
- R8: The accumulators saturate instead of wrapping, and they are cleared while the input is clipped. After the input returns from a clipped value into the linear span, the next 4096-bit window meets R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; accumulators advance on the rising edge, output bit on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 16 | Signed two's-complement input sample, held for many clocks |
| bit_out | output | 1 | Single-bit modulated stream |

## Verification
The bench sweeps the linear span in steps and adds both ends, then compares each measured ones count with 2048 + x/16. A wrong feedback magnitude or sign would tilt that slope or turn the loop into a runaway. The clip thresholds are probed on both sides: one code below, which must still toggle, and exactly at the threshold, which must be constant. An off-by-one compare, or a clip that depends on accumulator state, shows up there. A clipped episode followed by a linear input checks that a wrapping or uncleared accumulator cannot leave the density wrong afterwards. Every window also checks that the output never moves at a rising edge.

// File: rtl/dsm2_pkg.sv
`timescale 1ns/1ps
package dsm2_pkg;
   // Linear span limit: 9/16 of the input full scale.
   function automatic int lin_limit(input int in_w);
      return (9 * (1 << (in_w - 1))) / 16;
   endfunction

   // Clip threshold: 0.72 of full scale, rounded up to the next code.
   function automatic int clip_level(input int in_w);
      return (72 * (1 << (in_w - 1)) + 99) / 100;
   endfunction
endpackage

// File: rtl/dsm2_clip.sv
`timescale 1ns/1ps
module dsm2_clip #(
   parameter int IN_W = 16,
   parameter int CLIP = 23593
) (
   input  logic signed [IN_W-1:0] din,
   output logic                   clip_hi,
   output logic                   clip_lo
);
   localparam logic signed [IN_W:0] CLIP_P = (IN_W+1)'(CLIP);
   localparam logic signed [IN_W:0] CLIP_N = -CLIP_P;

   logic signed [IN_W:0] din_x;

   assign din_x   = (IN_W+1)'(din);
   assign clip_hi = (din_x >= CLIP_P);
   assign clip_lo = (din_x <= CLIP_N);
endmodule

// File: rtl/dsm2_integ.sv
`timescale 1ns/1ps
module dsm2_integ #(
   parameter int ACC_W    = 22,
   parameter bit SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic signed [ACC_W:0]   step,
   output logic signed [ACC_W-1:0] acc
);
   localparam int SUM_W = ACC_W + 2;
   localparam logic signed [SUM_W-1:0] MAXV = $signed({3'b000, {(ACC_W-1){1'b1}}});
   localparam logic signed [SUM_W-1:0] MINV = $signed({3'b111, {(ACC_W-1){1'b0}}});

   logic signed [SUM_W-1:0] sum;
   logic signed [ACC_W-1:0] nxt;

   assign sum = SUM_W'(acc) + SUM_W'(step);

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (sum > MAXV)      nxt = MAXV[ACC_W-1:0];
            else if (sum < MINV) nxt = MINV[ACC_W-1:0];
            else                 nxt = sum[ACC_W-1:0];
         end
      end else begin : g_wrap
         assign nxt = sum[ACC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else          acc <= nxt;
   end
endmodule

// File: rtl/dsm2_outreg.sv
`timescale 1ns/1ps
module dsm2_outreg (
   input  logic clk,
   input  logic rst_n,
   input  logic force_hi,
   input  logic force_lo,
   input  logic acc_neg,
   output logic bit_q
);
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)        bit_q <= 1'b0;
      else if (force_hi) bit_q <= 1'b1;
      else if (force_lo) bit_q <= 1'b0;
      else               bit_q <= ~acc_neg;
   end
endmodule

// File: rtl/dsm2_mod.sv
`timescale 1ns/1ps
module dsm2_mod
   import dsm2_pkg::*;
#(
   parameter int IN_W     = 16,
   parameter int ACC_W    = 22,
   parameter bit SATURATE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic signed [IN_W-1:0] din,
   output logic                   bit_out
);
   localparam int SW   = ACC_W + 1;
   localparam int FS   = 1 << (IN_W - 1);
   localparam int LIN  = lin_limit(IN_W);
   localparam int CLIP = clip_level(IN_W);
   localparam logic signed [SW-1:0] FB1 = SW'(FS);
   localparam logic signed [SW-1:0] FB2 = SW'(2 * FS);

   generate
      if (IN_W < 4 || IN_W > 24) begin : g_bad_in_w
         $error("dsm2_mod: IN_W out of supported range");
      end
      if (ACC_W < IN_W + 4) begin : g_bad_acc_w
         $error("dsm2_mod: ACC_W must exceed IN_W by at least 4");
      end
      if (!(LIN < CLIP && CLIP < FS)) begin : g_bad_levels
         $error("dsm2_mod: derived levels inconsistent");
      end
   endgenerate

   logic                    clip_hi, clip_lo, clip_any;
   logic signed [ACC_W-1:0] int1, int2;
   logic signed [SW-1:0]    step1, step2;
   logic signed [SW-1:0]    fb_a, fb_b;

   dsm2_clip #(.IN_W(IN_W), .CLIP(CLIP)) u_clip (
      .din     (din),
      .clip_hi (clip_hi),
      .clip_lo (clip_lo)
   );

   assign clip_any = clip_hi | clip_lo;

   // Feedback taken from the registered output bit (one clock behind).
   assign fb_a  = bit_out ? FB1 : -FB1;
   assign fb_b  = bit_out ? FB2 : -FB2;
   assign step1 = SW'(din) - fb_a;
   assign step2 = SW'(int1) - fb_b;

   dsm2_integ #(.ACC_W(ACC_W), .SATURATE(SATURATE)) u_int1 (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clip_any),
      .step  (step1),
      .acc   (int1)
   );

   dsm2_integ #(.ACC_W(ACC_W), .SATURATE(SATURATE)) u_int2 (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clip_any),
      .step  (step2),
      .acc   (int2)
   );

   dsm2_outreg u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_hi (clip_hi),
      .force_lo (clip_lo),
      .acc_neg  (int2[ACC_W-1]),
      .bit_q    (bit_out)
   );
endmodule

// File: rtl/dsm2_chk.sv
`timescale 1ns/1ps
module dsm2_chk #(
   parameter int IN_W  = 16,
   parameter int ACC_W = 22,
   parameter int CLIP  = 23593
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic signed [IN_W-1:0]  din,
   input logic                    bit_out,
   input logic signed [ACC_W-1:0] i2
);
   localparam logic signed [ACC_W-1:0] HALF_P = ACC_W'(1 << (ACC_W - 2));
   localparam logic signed [ACC_W-1:0] HALF_N = -HALF_P;
   localparam logic signed [IN_W:0]    CL_P   = (IN_W+1)'(CLIP);
   localparam logic signed [IN_W:0]    CL_N   = -CL_P;

   logic signed [IN_W:0] din_x;
   logic                 pos_q;

   assign din_x = (IN_W+1)'(din);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= 1'b0;
      else        pos_q <= bit_out;
   end

   // R1: output held low in reset
   p_rst_low_r1: assert property (@(posedge clk) !rst_n |-> !bit_out);

   // R5: clip forces constant ones / zeros
   p_clip_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && din_x >= CL_P && $past(din_x) >= CL_P) |-> bit_out);
   p_clip_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && din_x <= CL_N && $past(din_x) <= CL_N) |-> !bit_out);

   // R7: no change across a rising edge
   p_fall_only_r7: assert property (@(negedge clk) disable iff (!rst_n)
      bit_out == pos_q);

   // R8: second accumulator never wraps between extremes
   p_no_wrap_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(i2) > HALF_P) |-> (i2 >= 0));
   p_no_wrap_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(i2) < HALF_N) |-> (i2 <= 0));
endmodule

bind dsm2_mod dsm2_chk #(.IN_W(IN_W), .ACC_W(ACC_W), .CLIP(CLIP)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .din     (din),
   .bit_out (bit_out),
   .i2      (int2)
);

// File: tb/tb_dsm2_mod.sv
`timescale 1ns/1ps
module tb_dsm2_mod;
   localparam int WIN    = 4096;
   localparam int TOL    = 41;
   localparam int SETTLE = 32;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [15:0] din = '0;
   logic               bit_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   dsm2_mod dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (din),
      .bit_out (bit_out)
   );

   always #10 clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Apply x, settle, count ones over WIN bits; also check R7 per bit.
   task automatic run_window(input int x, output int ones);
      int edge_bad;
      logic a;
      ones = 0;
      edge_bad = 0;
      @(posedge clk); #2;
      din = 16'(x);
      repeat (SETTLE) @(posedge clk);
      for (int i = 0; i < WIN; i++) begin
         @(negedge clk); #5;
         a = bit_out;
         if (a) ones++;
         @(posedge clk); #5;
         if (bit_out !== a) edge_bad++;
      end
      check(edge_bad == 0, "R7", "changes at rising edge", edge_bad, 0);
   endtask

   function automatic int lin_exp(input int x);
      return 2048 + x / 16;
   endfunction

   task automatic check_lin(input int x, input string req);
      int n, e, d;
      run_window(x, n);
      e = lin_exp(x);
      d = (n > e) ? n - e : e - n;
      check(d <= TOL, req, $sformatf("ones for x=%0d", x), n, e);
   endtask

   task automatic check_band(input int x);
      int n;
      bit ok;
      run_window(x, n);
      if (x > 0) ok = (n >= 3200 - TOL) && (n < WIN);
      else       ok = (n <= 896 + TOL) && (n > 0);
      check(ok, "R6", $sformatf("band ones for x=%0d", x), n, (x > 0) ? 3200 : 896);
   endtask

   task automatic check_clip(input int x);
      int n, e;
      run_window(x, n);
      e = (x > 0) ? WIN : 0;
      check(n == e, "R5", $sformatf("clip ones for x=%0d", x), n, e);
   endtask

   initial begin
      #(190000 * 20);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n;
      // R1: reset state
      repeat (4) @(posedge clk);
      #5;
      check(bit_out == 1'b0, "R1", "output in reset", int'(bit_out), 0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      #3;
      check(bit_out == 1'b0, "R1", "output before first falling edge", int'(bit_out), 0);

      // R2: zero input
      check_lin(0, "R2");

      // R3: sweep of the linear span
      for (int x = -16384; x <= 16384; x += 4096) begin
         if (x != 0) check_lin(x, "R3");
      end
      check_lin(9000, "R3");
      check_lin(-5000, "R3");
      check_lin(1, "R3");

      // R4: ends of the linear span
      check_lin(18432, "R4");
      check_lin(-18432, "R4");

      // R6: nonlinear band, including one code below the clip
      check_band(21000);
      check_band(-21000);
      check_band(23592);
      check_band(-23592);

      // R5: clip exactly at threshold and at full scale
      check_clip(23593);
      check_clip(-23593);
      check_clip(32767);

      // R8: recovery from clipping back into the linear span
      check_lin(-9000, "R8");
      check_clip(-32768);
      check_lin(12000, "R8");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule